// File: doc/BRIEF.md
# Three-Level Gated Interrupt Controller

This block gathers single-cycle event pulses from the peripherals of a chip, latches each in its own sticky flag, and forwards a single interrupt request to the processor. A source gets through only when three gates are open: its own local enable bit, the mask bit of the module group it belongs to, and one global enable. Software sets the gates, clears flags, and locates the requesting source through a small word-addressed register port. Reads are combinational and writes take effect at the clock edge.

Sources are split into three module groups. Group 0 holds twenty-five sources: twenty-four external pin events and a timer event. It reports straight into the top identification register. Group 1 holds seven pin events, a supply-monitor event, eight I2C-master events and three SPI-slave events. It has its own identification register, in which all I2C-master events share one bit and all SPI-slave events share another. The three SPI-slave events also share one local enable. Group 2 holds the I2C-slave events, and its identification register has one bit for each event. When more than one group is requesting, the request output reports the lowest-numbered group.

Top module: `hier_irq_ctrl`

Register word addresses: 0 control (bit 0 global enable), 1 group mask (bit g masks group g), 2 top identification (read-only), 3 group-0 flags, 4 group-0 enables, 5 group-1 flags, 6 group-1 enables, 7 group-1 identification (read-only), 8 group-2 flags, 9 group-2 enables, 10 group-2 identification (read-only). Any other address reads 0.

## Requirements
- R1: After reset, every flag, every enable, the group mask and the global enable read 0, and `irq_o` is 0 with `irq_mod_o` 0.
- R2: A one-cycle pulse on a source input sets that source's flag at the next clock edge. The flag then stays set, whatever the other inputs do, until software clears it.
- R3: Writing a flag register clears each flag whose data bit is 1 and leaves each flag whose data bit is 0 unchanged. A set pulse that arrives in the same cycle as a clear of the same flag wins, so the flag stays 1.
- R4: `irq_o` is 1 only when control bit 0 (the global enable) is 1 and at least one top identification bit is 1.
- R5: Top identification bit g equals the group mask bit g ANDed with the OR, over all sources of group g, of flag AND local enable. Group 2's identification register bit k is flag k AND enable k.
- R6: When `irq_o` is 1, `irq_mod_o` gives the lowest-numbered set bit of the top identification register. When `irq_o` is 0, `irq_mod_o` is 0.
- R7: Group-1 flag and enable bits 0..6 are the seven pin events, bit 7 is the supply event, and flag bits 8..15 are the eight I2C-master events, each with an enable at the same bit. Group-1 identification bits 0..7 follow flags 0..7 one-to-one, and bit 8 is the OR of the eight enabled I2C-master events.
- R8: Group-1 flag bits 16..18 are the three SPI-slave events. They share the single enable at group-1 enable bit 16. Group-1 identification bit 9 is that enable ANDed with the OR of the three flags.
- R9: Writes to the identification registers have no effect.
- R10: Group-0 flag and enable bits 0..23 are the pin events and bit 24 is the timer event. Group 0 has no identification register of its own and feeds top identification bit 0 directly.
- R11: One write to the group-mask register opens and closes any combination of groups in the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| m0_set_i | input | 25 | Group-0 event pulses (bit 24 timer) |
| m1_set_i | input | 19 | Group-1 event pulses |
| m2_set_i | input | 4 | Group-2 (I2C-slave) event pulses |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| irq_o | output | 1 | Interrupt request to the processor |
| irq_mod_o | output | 2 | Index of the lowest requesting group |

## Verification
A source's set pulse and a software clear of the same flag can land on the same clock edge, and the set has to win. The bench drives the pulse on `m2_set_i` and a write of 1 to the group-2 flag register in the same cycle, then reads the flag back in the following cycle and expects 1. It also checks the plain cases on both sides of that collision: a write of 0 leaves a flag set, and a write of 1 with no pulse clears it.

// File: rtl/hier_irq_pkg.sv
package hier_irq_pkg;

    localparam int NUM_GRP   = 3;
    localparam int GRP_IDX_W = $clog2(NUM_GRP);

    typedef enum logic [3:0] {
        RA_CTRL   = 4'd0,
        RA_MASK   = 4'd1,
        RA_TOPID  = 4'd2,
        RA_G0FLAG = 4'd3,
        RA_G0EN   = 4'd4,
        RA_G1FLAG = 4'd5,
        RA_G1EN   = 4'd6,
        RA_G1ID   = 4'd7,
        RA_G2FLAG = 4'd8,
        RA_G2EN   = 4'd9,
        RA_G2ID   = 4'd10
    } reg_addr_e;

endpackage

// File: rtl/irq_src_bank.sv
// Sticky flags with write-one-to-clear, plus a plain enable register.
module irq_src_bank #(
    parameter int NF = 8,
    parameter int NE = 8,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NF-1:0] set_i,
    input  logic          clr_we_i,
    input  logic          en_we_i,
    input  logic [DW-1:0] wdata_i,
    output logic [NF-1:0] flag_o,
    output logic [NE-1:0] en_o
);

    logic [NF-1:0] flag_q;
    logic [NE-1:0] en_q;
    logic [NF-1:0] clr_mask;

    assign clr_mask = clr_we_i ? wdata_i[NF-1:0] : '0;

    for (genvar i = 0; i < NF; i++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                flag_q[i] <= 1'b0;
            end else if (set_i[i]) begin
                flag_q[i] <= 1'b1;
            end else if (clr_mask[i]) begin
                flag_q[i] <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (en_we_i) begin
            en_q <= wdata_i[NE-1:0];
        end
    end

    assign flag_o = flag_q;
    assign en_o   = en_q;

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_i) |=> ((flag_q & $past(set_i)) == $past(set_i))); // R3

    AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!(|set_i) && !clr_we_i) |=> (flag_q == $past(flag_q))); // R2

    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we_i |=> ((flag_q & $past(wdata_i[NF-1:0] & ~set_i)) == '0)); // R3

endmodule

// File: rtl/irq_g1_ident.sv
// Folds group-1 flags into its identification word.
module irq_g1_ident #(
    parameter int N_PIN  = 7,
    parameter int N_I2CM = 8,
    parameter int N_SPI  = 3,
    localparam int N_DIRECT = N_PIN + 1,
    localparam int NF       = N_DIRECT + N_I2CM + N_SPI,
    localparam int NE       = N_DIRECT + N_I2CM + 1,
    localparam int NID      = N_DIRECT + 2
) (
    input  logic [NF-1:0]  flag_i,
    input  logic [NE-1:0]  en_i,
    output logic [NID-1:0] id_o,
    output logic           req_o
);

    localparam int I2CM_LO = N_DIRECT;
    localparam int SPI_LO  = N_DIRECT + N_I2CM;
    localparam int SPI_EN  = N_DIRECT + N_I2CM;

    for (genvar i = 0; i < N_DIRECT; i++) begin : g_direct
        assign id_o[i] = flag_i[i] & en_i[i];
    end

    assign id_o[N_DIRECT]     = |(flag_i[I2CM_LO +: N_I2CM] & en_i[I2CM_LO +: N_I2CM]);
    assign id_o[N_DIRECT + 1] = (|flag_i[SPI_LO +: N_SPI]) & en_i[SPI_EN];
    assign req_o              = |id_o;

endmodule

// File: rtl/irq_grp_arbiter.sv
// Applies group mask and global enable, picks the lowest group.
module irq_grp_arbiter #(
    parameter int NG = 3,
    localparam int IW = (NG > 1) ? $clog2(NG) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          gen_i,
    input  logic [NG-1:0] grp_req_i,
    input  logic [NG-1:0] mask_i,
    output logic [NG-1:0] top_id_o,
    output logic          irq_o,
    output logic [IW-1:0] irq_grp_o
);

    logic [IW-1:0] pick;

    assign top_id_o = grp_req_i & mask_i;

    always_comb begin
        pick = '0;
        for (int g = NG - 1; g >= 0; g--) begin
            if (top_id_o[g]) pick = IW'(g);
        end
    end

    assign irq_o     = gen_i & (|top_id_o);
    assign irq_grp_o = irq_o ? pick : '0;

    AST_LOWEST_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (top_id_o[irq_grp_o] &&
                   ((top_id_o & ((NG'(1) << irq_grp_o) - NG'(1))) == '0))); // R6

endmodule

// File: rtl/hier_irq_ctrl.sv
module hier_irq_ctrl
    import hier_irq_pkg::*;
#(
    parameter int DW     = 32,
    parameter int AW     = 4,
    parameter int N_G0   = 25,
    parameter int N_PIN1 = 7,
    parameter int N_I2CM = 8,
    parameter int N_SPI  = 3,
    parameter int N_G2   = 4,
    localparam int N_G1F = N_PIN1 + 1 + N_I2CM + N_SPI,
    localparam int N_G1E = N_PIN1 + 1 + N_I2CM + 1,
    localparam int N_G1I = N_PIN1 + 1 + 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N_G0-1:0]      m0_set_i,
    input  logic [N_G1F-1:0]     m1_set_i,
    input  logic [N_G2-1:0]      m2_set_i,
    input  logic                 reg_we_i,
    input  logic [AW-1:0]        reg_addr_i,
    input  logic [DW-1:0]        reg_wdata_i,
    output logic [DW-1:0]        reg_rdata_o,
    output logic                 irq_o,
    output logic [GRP_IDX_W-1:0] irq_mod_o
);

    logic                 gen_q;
    logic [NUM_GRP-1:0]   mask_q;
    logic [N_G0-1:0]      g0_flag, g0_en;
    logic [N_G1F-1:0]     g1_flag;
    logic [N_G1E-1:0]     g1_en;
    logic [N_G1I-1:0]     g1_id;
    logic [N_G2-1:0]      g2_flag, g2_en, g2_id;
    logic [NUM_GRP-1:0]   grp_req, top_id;
    logic                 g1_req;

    function automatic logic hit(input logic [AW-1:0] a, input reg_addr_e r);
        return reg_we_i && (a == AW'(r));
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gen_q  <= 1'b0;
            mask_q <= '0;
        end else begin
            if (hit(reg_addr_i, RA_CTRL)) gen_q  <= reg_wdata_i[0];
            if (hit(reg_addr_i, RA_MASK)) mask_q <= reg_wdata_i[NUM_GRP-1:0];
        end
    end

    irq_src_bank #(.NF(N_G0), .NE(N_G0), .DW(DW)) u_g0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (m0_set_i),
        .clr_we_i (hit(reg_addr_i, RA_G0FLAG)),
        .en_we_i  (hit(reg_addr_i, RA_G0EN)),
        .wdata_i  (reg_wdata_i),
        .flag_o   (g0_flag),
        .en_o     (g0_en)
    );

    irq_src_bank #(.NF(N_G1F), .NE(N_G1E), .DW(DW)) u_g1 (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (m1_set_i),
        .clr_we_i (hit(reg_addr_i, RA_G1FLAG)),
        .en_we_i  (hit(reg_addr_i, RA_G1EN)),
        .wdata_i  (reg_wdata_i),
        .flag_o   (g1_flag),
        .en_o     (g1_en)
    );

    irq_src_bank #(.NF(N_G2), .NE(N_G2), .DW(DW)) u_g2 (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (m2_set_i),
        .clr_we_i (hit(reg_addr_i, RA_G2FLAG)),
        .en_we_i  (hit(reg_addr_i, RA_G2EN)),
        .wdata_i  (reg_wdata_i),
        .flag_o   (g2_flag),
        .en_o     (g2_en)
    );

    irq_g1_ident #(.N_PIN(N_PIN1), .N_I2CM(N_I2CM), .N_SPI(N_SPI)) u_g1_id (
        .flag_i (g1_flag),
        .en_i   (g1_en),
        .id_o   (g1_id),
        .req_o  (g1_req)
    );

    assign g2_id   = g2_flag & g2_en;
    assign grp_req = {|g2_id, g1_req, |(g0_flag & g0_en)};

    irq_grp_arbiter #(.NG(NUM_GRP)) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .gen_i     (gen_q),
        .grp_req_i (grp_req),
        .mask_i    (mask_q),
        .top_id_o  (top_id),
        .irq_o     (irq_o),
        .irq_grp_o (irq_mod_o)
    );

    always_comb begin
        reg_rdata_o = '0;
        case (reg_addr_i)
            AW'(RA_CTRL):   reg_rdata_o[0]           = gen_q;
            AW'(RA_MASK):   reg_rdata_o[NUM_GRP-1:0] = mask_q;
            AW'(RA_TOPID):  reg_rdata_o[NUM_GRP-1:0] = top_id;
            AW'(RA_G0FLAG): reg_rdata_o[N_G0-1:0]    = g0_flag;
            AW'(RA_G0EN):   reg_rdata_o[N_G0-1:0]    = g0_en;
            AW'(RA_G1FLAG): reg_rdata_o[N_G1F-1:0]   = g1_flag;
            AW'(RA_G1EN):   reg_rdata_o[N_G1E-1:0]   = g1_en;
            AW'(RA_G1ID):   reg_rdata_o[N_G1I-1:0]   = g1_id;
            AW'(RA_G2FLAG): reg_rdata_o[N_G2-1:0]    = g2_flag;
            AW'(RA_G2EN):   reg_rdata_o[N_G2-1:0]    = g2_en;
            AW'(RA_G2ID):   reg_rdata_o[N_G2-1:0]    = g2_id;
            default:        reg_rdata_o = '0;
        endcase
    end

    AST_QUIET_WITHOUT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (!(|g0_flag) && !(|g1_flag) && !(|g2_flag)) |-> !irq_o); // R5

endmodule

// File: tb/hier_irq_ctrl_tb.sv
module hier_irq_ctrl_tb;

    localparam int K_WR = 0, K_RD = 1, K_P0 = 2, K_P1 = 3, K_P2 = 4, K_IRQ = 5;

    typedef struct packed {
        logic [2:0]  kind;
        logic [3:0]  addr;
        logic [31:0] data;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 56;
    localparam vec_t VEC [NV] = '{
        '{3'(K_RD),  4'd0,  32'h0,        8'd1},  // R1 control
        '{3'(K_RD),  4'd1,  32'h0,        8'd1},  // R1 mask
        '{3'(K_RD),  4'd3,  32'h0,        8'd1},  // R1 flags
        '{3'(K_IRQ), 4'd0,  32'h0,        8'd1},  // R1 request
        '{3'(K_P0),  4'd0,  32'h8,        8'd2},
        '{3'(K_RD),  4'd3,  32'h8,        8'd2},  // R2 flag set
        '{3'(K_RD),  4'd2,  32'h0,        8'd5},  // R5 local enable closed
        '{3'(K_WR),  4'd4,  32'h8,        8'd5},
        '{3'(K_RD),  4'd2,  32'h0,        8'd5},  // R5 mask closed
        '{3'(K_WR),  4'd1,  32'h1,        8'd5},
        '{3'(K_RD),  4'd2,  32'h1,        8'd5},  // R5 all open
        '{3'(K_IRQ), 4'd0,  32'h0,        8'd4},  // R4 global off
        '{3'(K_WR),  4'd0,  32'h1,        8'd4},
        '{3'(K_IRQ), 4'd0,  32'h4,        8'd4},  // R4 global on
        '{3'(K_P1),  4'd0,  32'h400,      8'd7},
        '{3'(K_WR),  4'd6,  32'h400,      8'd7},
        '{3'(K_RD),  4'd7,  32'h100,      8'd7},  // R7 I2C master share bit
        '{3'(K_WR),  4'd1,  32'h2,        8'd11},
        '{3'(K_IRQ), 4'd0,  32'h5,        8'd11}, // R11 swap groups in one write
        '{3'(K_RD),  4'd2,  32'h2,        8'd11}, // R11
        '{3'(K_WR),  4'd1,  32'h7,        8'd6},
        '{3'(K_IRQ), 4'd0,  32'h4,        8'd6},  // R6 lowest group
        '{3'(K_WR),  4'd3,  32'h0,        8'd3},
        '{3'(K_RD),  4'd3,  32'h8,        8'd3},  // R3 zero write keeps
        '{3'(K_WR),  4'd3,  32'h8,        8'd3},
        '{3'(K_RD),  4'd3,  32'h0,        8'd3},  // R3 one write clears
        '{3'(K_IRQ), 4'd0,  32'h5,        8'd6},  // R6 next group
        '{3'(K_P1),  4'd0,  32'h70000,    8'd2},
        '{3'(K_RD),  4'd5,  32'h70400,    8'd2},  // R2 flags accumulate
        '{3'(K_RD),  4'd7,  32'h100,      8'd8},  // R8 shared enable off
        '{3'(K_WR),  4'd6,  32'h10400,    8'd8},
        '{3'(K_RD),  4'd7,  32'h300,      8'd8},  // R8 shared enable on
        '{3'(K_WR),  4'd5,  32'h400,      8'd3},
        '{3'(K_RD),  4'd7,  32'h200,      8'd3},  // R3 selective clear
        '{3'(K_WR),  4'd7,  32'hFFFF,     8'd9},
        '{3'(K_RD),  4'd7,  32'h200,      8'd9},  // R9 group-1 id read-only
        '{3'(K_WR),  4'd2,  32'h0,        8'd9},
        '{3'(K_RD),  4'd2,  32'h2,        8'd9},  // R9 top id read-only
        '{3'(K_P1),  4'd0,  32'h80,       8'd7},
        '{3'(K_WR),  4'd6,  32'h10480,    8'd7},
        '{3'(K_RD),  4'd7,  32'h280,      8'd7},  // R7 supply bit
        '{3'(K_WR),  4'd5,  32'h70480,    8'd3},
        '{3'(K_RD),  4'd7,  32'h0,        8'd3},  // R3 clear all
        '{3'(K_IRQ), 4'd0,  32'h0,        8'd4},  // R4 nothing pending
        '{3'(K_P0),  4'd0,  32'h1000000,  8'd10},
        '{3'(K_WR),  4'd4,  32'h1000000,  8'd10},
        '{3'(K_RD),  4'd2,  32'h1,        8'd10}, // R10 timer into top bit 0
        '{3'(K_IRQ), 4'd0,  32'h4,        8'd10}, // R10
        '{3'(K_WR),  4'd3,  32'h1000000,  8'd5},
        '{3'(K_P2),  4'd0,  32'h2,        8'd5},
        '{3'(K_WR),  4'd9,  32'h2,        8'd5},
        '{3'(K_RD),  4'd10, 32'h2,        8'd5},  // R5 group-2 id
        '{3'(K_IRQ), 4'd0,  32'h6,        8'd6},  // R6 group 2
        '{3'(K_WR),  4'd0,  32'h0,        8'd4},
        '{3'(K_IRQ), 4'd0,  32'h0,        8'd4},  // R4 global cleared
        '{3'(K_RD),  4'd8,  32'h2,        8'd2}   // R2 flag outlives gating
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [24:0] m0_set = '0;
    logic [18:0] m1_set = '0;
    logic [3:0]  m2_set = '0;
    logic        we = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;
    logic [1:0]  irq_mod;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    hier_irq_ctrl u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .m0_set_i    (m0_set),
        .m1_set_i    (m1_set),
        .m2_set_i    (m2_set),
        .reg_we_i    (we),
        .reg_addr_i  (addr),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .irq_o       (irq),
        .irq_mod_o   (irq_mod)
    );

    task automatic check(input int r, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL R%0d actual=%h expected=%h", r, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd_chk(input int r, input logic [3:0] a, input logic [31:0] e);
        @(negedge clk);
        addr = a;
        #1;
        check(r, rdata, e);
    endtask

    task automatic irq_chk(input int r, input logic [2:0] e);
        @(negedge clk);
        #1;
        check(r, {29'd0, irq, irq_mod}, {29'd0, e});
    endtask

    initial begin
        #200000;
        n_bad++;
        $display("FAIL watchdog expired: actual=hung expected=done");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            case (int'(VEC[i].kind))
                K_WR:  wr(VEC[i].addr, VEC[i].data);
                K_RD:  rd_chk(int'(VEC[i].req), VEC[i].addr, VEC[i].data);
                K_IRQ: irq_chk(int'(VEC[i].req), VEC[i].data[2:0]);
                K_P0: begin
                    @(negedge clk); m0_set = VEC[i].data[24:0];
                    @(negedge clk); m0_set = '0;
                end
                K_P1: begin
                    @(negedge clk); m1_set = VEC[i].data[18:0];
                    @(negedge clk); m1_set = '0;
                end
                default: begin
                    @(negedge clk); m2_set = VEC[i].data[3:0];
                    @(negedge clk); m2_set = '0;
                end
            endcase
        end

        // R3: clear alone, then set and clear in the same cycle
        wr(4'd8, 32'h2);
        rd_chk(3, 4'd8, 32'h0);
        @(negedge clk);
        m2_set = 4'h2; we = 1'b1; addr = 4'd8; wdata = 32'h2;
        @(negedge clk);
        m2_set = '0; we = 1'b0;
        rd_chk(3, 4'd8, 32'h2);

        // R1: reset in mid-run with state loaded
        wr(4'd0, 32'h1);
        irq_chk(1, 3'h6);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        rd_chk(1, 4'd0, 32'h0);
        rd_chk(1, 4'd1, 32'h0);
        rd_chk(1, 4'd8, 32'h0);
        rd_chk(1, 4'd9, 32'h0);
        irq_chk(1, 3'h0);

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule